// File: doc/BRIEF.md
# Periodic PWM Comparison Scheduler

The scheduler watches a free-running PWM reference counter and raises a one-clock match pulse when that counter reaches a programmed compare value. It does this only in chosen periods. A 4-bit slot counter steps once per reference period and wraps after a programmable limit. The comparison is armed only in the period whose slot number equals a programmable trigger slot. So with a limit of L, at most one period in every L+1 can produce a match.

Software writes an enable, the trigger slot, the slot limit, a reload interval and the compare value. These writes land in shadow copies. The comparison keeps using its active copies until a second counter, the reload counter, wraps at the end of its interval. At that period boundary all shadow settings move into the active copies together. Software therefore never sees a half-applied change in the middle of a cycle.

The mode word reads back the shadow settings and the live values of both counters.

Top module: `pwm_cmp_sched`

## Requirements
- R1: After reset, `match` is 0 and `mode_rd` reads 0. Both counters, all shadow settings and all active settings are zero.
- R2: The slot counter changes only on a clock with `period_end` high. On that clock it goes to 0 if it is at or above the active limit. Otherwise it increments. It reads at `mode_rd[15:12]`.
- R3: `match` is only asserted while the slot counter equals the active trigger slot.
- R4: While the active enable is 0, `match` stays 0.
- R5: In an armed period, `match` is high for exactly one clock when `ref_cnt` equals the active compare value. If `ref_cnt` holds that value for several clocks, only the first clock pulses.
- R6: A write with `wr_sel`=0 updates the shadow enable, trigger, limit and reload interval. A write with `wr_sel`=1 updates the shadow compare value from `wr_data[CNT_W-1:0]`. Shadow settings reach the active copies only on a `period_end` clock where the reload counter is at or above the active reload interval.
- R7: The reload counter steps on `period_end`. It wraps to 0 after reaching the active interval, so one reload cycle spans interval+1 periods. It reads at `mode_rd[23:20]`.
- R8: Written bits 31:24, 15:12, 3:1 and 23:20 of the mode word are ignored. The two counter fields keep counting and read their own values.
- R9: The mode word layout is: enable at bit 0, trigger slot at 7:4, slot limit at 11:8, slot counter at 15:12, reload interval at 19:16 and reload counter at 23:20. Bits 31:24 and 3:1 read 0.
- R10: If the active trigger slot is greater than the active limit, no match occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_cnt | input | CNT_W | Reference PWM counter value |
| period_end | input | 1 | One-clock strobe on the last clock of a reference period |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = mode word, 1 = compare value |
| wr_data | input | 32 | Write data |
| mode_rd | output | 32 | Mode word readback |
| match | output | 1 | One-clock match pulse |

## Verification
The bench goes after settings that change in the middle of a reload cycle. A design that applied writes at once would pulse in the wrong slot or at the wrong value. It also sets a trigger slot beyond the limit, and lowers the limit under a running slot counter. A design that failed to gate these would pulse in a slot that does not exist. The reference counter is randomly stalled on the compare value, so that a level-sensitive match shows up as a multi-clock pulse. Random writes put ones into the counter fields and unused bits, which catches a design that lets software overwrite its counters.

// File: rtl/pwm_cmp_sched.sv
module pwm_cmp_sched #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] ref_cnt,
  input  logic             period_end,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [31:0]      wr_data,
  output logic [31:0]      mode_rd,
  output logic             match
);
  localparam int FW = 4;

  logic             sh_cen, act_cen;
  logic [FW-1:0]    sh_ctr, sh_cpr, sh_cupr;
  logic [FW-1:0]    act_ctr, act_cpr, act_cupr;
  logic [CNT_W-1:0] sh_val, act_val;
  logic [FW-1:0]    slot_cnt, rld_cnt;
  logic             hit, hit_q;

  wire slot_wrap = slot_cnt >= act_cpr;
  wire rld_wrap  = rld_cnt >= act_cupr;
  wire reload    = period_end && rld_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_cen  <= 1'b0;
      sh_ctr  <= '0;
      sh_cpr  <= '0;
      sh_cupr <= '0;
      sh_val  <= '0;
    end else if (wr_en) begin
      if (wr_sel) begin
        sh_val <= wr_data[CNT_W-1:0];
      end else begin
        sh_cen  <= wr_data[0];
        sh_ctr  <= wr_data[7:4];
        sh_cpr  <= wr_data[11:8];
        sh_cupr <= wr_data[19:16];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_cen  <= 1'b0;
      act_ctr  <= '0;
      act_cpr  <= '0;
      act_cupr <= '0;
      act_val  <= '0;
    end else if (reload) begin
      act_cen  <= sh_cen;
      act_ctr  <= sh_ctr;
      act_cpr  <= sh_cpr;
      act_cupr <= sh_cupr;
      act_val  <= sh_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_cnt <= '0;
      rld_cnt  <= '0;
    end else if (period_end) begin
      slot_cnt <= slot_wrap ? '0 : slot_cnt + 1'b1;
      rld_cnt  <= rld_wrap  ? '0 : rld_cnt + 1'b1;
    end
  end

  assign hit = act_cen && (slot_cnt == act_ctr) && (slot_cnt <= act_cpr)
               && (ref_cnt == act_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit;
  end

  assign match   = hit && !hit_q;
  assign mode_rd = {8'h00, rld_cnt, sh_cupr, slot_cnt, sh_cpr, sh_ctr, 3'b000, sh_cen};
endmodule

module pwm_cmp_sched_chk #(
  parameter int CNT_W = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        period_end,
  input logic        match,
  input logic [31:0] mode_rd,
  input logic [3:0]  slot_cnt,
  input logic [3:0]  rld_cnt,
  input logic        act_cen,
  input logic [3:0]  act_ctr,
  input logic [3:0]  act_cpr,
  input logic [3:0]  act_cupr
);
  // R4
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act_cen |-> !match);
  // R3
  slot_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> (slot_cnt == act_ctr));
  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> !match);
  // R2
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(slot_cnt) && $stable(rld_cnt));
  // R6
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(period_end && rld_cnt >= act_cupr) |=>
      $stable(act_cen) && $stable(act_ctr) && $stable(act_cpr) && $stable(act_cupr));
  // R9
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_rd[31:24] == 8'h00 && mode_rd[3:1] == 3'b000);
  // R10
  slot_beyond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_ctr > act_cpr) |-> !match);
endmodule

bind pwm_cmp_sched pwm_cmp_sched_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .period_end(period_end), .match(match),
  .mode_rd(mode_rd), .slot_cnt(slot_cnt), .rld_cnt(rld_cnt),
  .act_cen(act_cen), .act_ctr(act_ctr), .act_cpr(act_cpr), .act_cupr(act_cupr)
);

// File: tb/pwm_cmp_sched_test.sv
module pwm_cmp_sched_test;
  localparam int CLK_PER = 10;
  localparam int CNT_W   = 16;
  localparam int PMAX    = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] ref_cnt = '0;
  logic             period_end = 1'b0;
  logic             wr_en = 1'b0;
  logic             wr_sel = 1'b0;
  logic [31:0]      wr_data = '0;
  logic [31:0]      mode_rd;
  logic             match;

  int errors = 0;
  int checks = 0;

  pwm_cmp_sched #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .ref_cnt(ref_cnt), .period_end(period_end),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .mode_rd(mode_rd), .match(match)
  );

  always #(CLK_PER/2) clk = ~clk;

  // bench model state
  logic       s_cen, a_cen, m_hq;
  logic [3:0] s_ctr, s_cpr, s_cupr, a_ctr, a_cpr, a_cupr, m_slot, m_rld;
  logic [CNT_W-1:0] s_val, a_val;
  int r = 0;

  function automatic logic [31:0] exp_rd();
    return {8'h00, m_rld, s_cupr, m_slot, s_cpr, s_ctr, 3'b000, s_cen};
  endfunction

  function automatic logic exp_hit(input int rv);
    return a_cen && m_slot == a_ctr && m_slot <= a_cpr && rv[CNT_W-1:0] == a_val;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    s_cen = 0; a_cen = 0; m_hq = 0;
    s_ctr = 0; s_cpr = 0; s_cupr = 0; a_ctr = 0; a_cpr = 0; a_cupr = 0;
    m_slot = 0; m_rld = 0; s_val = 0; a_val = 0; r = 0;
  endtask

  // one clock: drive at negedge, check, advance model as the posedge will
  task automatic step(input logic we, input logic sel, input logic [31:0] d, input logic stall);
    logic h, pe;
    @(negedge clk);
    ref_cnt = r[CNT_W-1:0];
    pe = (r == PMAX);
    period_end = pe;
    wr_en = we; wr_sel = sel; wr_data = d;
    #1;
    h = exp_hit(r);
    if (!a_cen) check("R4 match", {31'b0, match}, 32'd0);
    else if (a_ctr > a_cpr) check("R10 match", {31'b0, match}, 32'd0);
    else check("R3 R5 R6 match", {31'b0, match}, {31'b0, h && !m_hq});
    check("R2 R7 R8 R9 readback", mode_rd, exp_rd());
    m_hq = h;
    if (pe) begin
      if (m_rld >= a_cupr) begin
        a_cen = s_cen; a_ctr = s_ctr; a_cpr = s_cpr; a_cupr = s_cupr; a_val = s_val;
      end
      m_slot = (m_slot >= a_cpr_prev(m_slot)) ? 4'd0 : m_slot + 4'd1;
    end
    if (we) begin
      if (sel) s_val = d[CNT_W-1:0];
      else begin s_cen = d[0]; s_ctr = d[7:4]; s_cpr = d[11:8]; s_cupr = d[19:16]; end
    end
    if (pe || !stall) r = (r == PMAX) ? 0 : r + 1;
  endtask

  // holds the limit in force before the reload on this edge
  logic [3:0] cpr_before, cupr_before;
  function automatic logic [3:0] a_cpr_prev(input logic [3:0] dummy);
    return cpr_before;
  endfunction

  task automatic cyc(input logic we, input logic sel, input logic [31:0] d, input logic stall);
    cpr_before = a_cpr;
    cupr_before = a_cupr;
    step2(we, sel, d, stall);
  endtask

  task automatic step2(input logic we, input logic sel, input logic [31:0] d, input logic stall);
    logic [3:0] rld_old;
    rld_old = m_rld;
    step(we, sel, d, stall);
    if (period_end) m_rld = (rld_old >= cupr_before) ? 4'd0 : rld_old + 4'd1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 32'd0, 1'b0);
  endtask

  function automatic logic [31:0] mk_mode(input logic en, input int ctr, input int cpr, input int cupr);
    return {12'h000, cupr[3:0], 4'h0, cpr[3:0], ctr[3:0], 3'b000, en};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 match", {31'b0, match}, 32'd0);
    check("R1 readback", mode_rd, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // plain enable, every period armed
    cyc(1'b1, 1'b1, 32'd3, 1'b0);
    cyc(1'b1, 1'b0, mk_mode(1, 0, 0, 0), 1'b0);
    idle(40);

    // R2 R3: one slot out of three, reload every four periods
    cyc(1'b1, 1'b0, mk_mode(1, 1, 2, 3), 1'b0);
    idle(120);

    // R6: mid-cycle change of value and slot
    cyc(1'b1, 1'b1, 32'd1, 1'b0);
    cyc(1'b1, 1'b0, mk_mode(1, 2, 2, 3), 1'b0);
    idle(100);

    // R10: trigger slot beyond limit
    cyc(1'b1, 1'b0, mk_mode(1, 7, 3, 1), 1'b0);
    idle(100);

    // R4: disabled
    cyc(1'b1, 1'b0, mk_mode(0, 0, 0, 0), 1'b0);
    idle(60);

    // R8: ones in read-only and unused bits
    cyc(1'b1, 1'b0, 32'hFFF0_F00E | mk_mode(1, 0, 1, 2), 1'b0);
    idle(60);

    // R2: lower the limit under a running slot counter
    cyc(1'b1, 1'b0, mk_mode(1, 9, 12, 0), 1'b0);
    idle(80);
    cyc(1'b1, 1'b0, mk_mode(1, 1, 2, 0), 1'b0);
    idle(80);

    // R5: stalled reference counter on the compare value
    cyc(1'b1, 1'b0, mk_mode(1, 0, 0, 0), 1'b0);
    for (int i = 0; i < 300; i++) cyc(1'b0, 1'b0, 32'd0, ($urandom % 2) == 0);

    // random mix
    for (int i = 0; i < 6000; i++) begin
      int k;
      k = $urandom % 16;
      if (k == 0)      cyc(1'b1, 1'b0, $urandom & 32'hFFFF_F3F1 | mk_mode(1, $urandom % 4, $urandom % 4, 0) & 32'h0000_0FF1, ($urandom % 3) == 0);
      else if (k == 1) cyc(1'b1, 1'b0, $urandom, ($urandom % 3) == 0);
      else if (k == 2) cyc(1'b1, 1'b1, $urandom % (PMAX + 2), ($urandom % 3) == 0);
      else             cyc(1'b0, 1'b0, 32'd0, ($urandom % 3) == 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule